// File: doc/BRIEF.md
# Serial Byte Transmitter with Idle Queueing

This block turns bytes written by a host into asynchronous serial frames on a single output line. A byte written into the one-entry holding buffer moves into the shifter at the next baud tick that finds the line free. It then leaves as one start bit at the space level, eight data bits least significant bit first, and one stop bit at the mark level. Each bit lasts one baud tick period. The baud tick is a single-cycle pulse supplied from outside the block.

Two more character kinds can be sent, and each lasts ten bit times. An idle character holds the mark level. It is queued each time the transmit enable goes from 0 back to 1, and it is sent after the frame in flight and ahead of any waiting byte. A break character holds the space level, and one is sent for every character slot in which the break request is 1. A polarity control inverts every level on the line. Two status flags, buffer empty and transmission complete, each have their own interrupt enable. These drive a shared interrupt request.

Top module: `uart_tx_idleq`

## Requirements
- R1: After reset the line rests at the mark level, buffer empty reads 1, transmission complete reads 1, and the interrupt request is 0 while both interrupt enables are 0.
- R2: A byte is sent as one 0 start bit, then data bits 0 to 7 in that order, then one 1 stop bit. Each bit begins at a baud tick, and the line does not change between ticks.
- R3: When the polarity control is 1, every level on the line is inverted: resting level, idle, break, start, data and stop bits.
- R4: A host write clears buffer empty in the next cycle. Buffer empty returns to 1 in the cycle after the baud tick that moves the byte into the shifter.
- R5: Transmission complete is 1 only when the shifter is free, the buffer is empty, no idle character is queued and no break is requested with the enable at 1. It goes to 0 in the cycle after a write or a queueing.
- R6: Each 0-to-1 change of the enable queues one idle character of ten mark bit times. It follows the frame being sent and comes before the buffered byte.
- R7: If the enable is 0 during any cycle of a frame's stop bit, the next 0-to-1 change of the enable discards the buffered byte: buffer empty reads 1 and the byte is never sent. An idle character is still queued.
- R8: A break request with the enable at 1 sends characters of ten space bit times. When a character slot starts, a queued idle character goes first, then a break, then buffered data.
- R9: With the enable at 0 the block finishes the character in progress, then holds the resting level and starts nothing new. A byte written meanwhile stays in the buffer.
- R10: The interrupt request is 1 exactly when buffer empty and its enable are both 1, or transmission complete and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| tx_en | input | 1 | Transmit enable; a 0-to-1 change queues an idle character |
| tx_inv | input | 1 | Inverts every level on the output line |
| brk_req | input | 1 | Requests break characters |
| wr_stb | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| irq_empty_en | input | 1 | Lets buffer empty raise the interrupt |
| irq_done_en | input | 1 | Lets transmission complete raise the interrupt |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default eight-bit data width and pulses the baud tick once every four clocks. That makes a whole ten-bit character forty cycles long, so the bench can check every bit of a frame, a queued idle character and a break by sampling the line once per tick. The short bit time also lets the bench time enable toggles to fall before the stop bit or inside it, with room between ticks for writes and toggles. This brings both the kept-byte and the discarded-byte outcome of an idle queueing within reach, along with the order in which a break and buffered data share the line.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;

    // Kind of character currently occupying the shifter
    typedef enum logic [1:0] {
        CH_NONE  = 2'd0,
        CH_DATA  = 2'd1,
        CH_IDLE  = 2'd2,
        CH_BREAK = 2'd3
    } char_kind_e;

    // Pending work offered to the shifter at a character boundary
    typedef struct packed {
        logic idle;
        logic brk;
        logic data;
    } txq_req_t;

    // Bit slots per character: start + data + stop
    function automatic int char_bits(input int data_w);
        return data_w + 2;
    endfunction

    // Priority at a character boundary: idle, then break, then data
    function automatic char_kind_e pick_next(input txq_req_t r);
        if (r.idle)
            return CH_IDLE;
        else if (r.brk)
            return CH_BREAK;
        else if (r.data)
            return CH_DATA;
        return CH_NONE;
    endfunction

endpackage

// File: rtl/uart_txq_hold.sv
module uart_txq_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              drop,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (wr_stb) begin
                full <= 1'b1;
                data <= wr_data;
            end else if (take || drop) begin
                full <= 1'b0;
            end
        end
    end

    assert_write_fills_R4: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> full);

    assert_take_empties_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_stb) |=> !full);

    assert_drop_empties_R7: assert property (@(posedge clk) disable iff (rst)
        (drop && !wr_stb) |=> !full);

endmodule

// File: rtl/uart_txq_enq.sv
module uart_txq_enq (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic in_stop,
    input  logic take_idle,
    output logic idle_pend,
    output logic discard
);

    logic en_q;
    logic late;
    logic rise;

    assign rise    = tx_en && !en_q;
    assign discard = rise && late;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            late      <= 1'b0;
            idle_pend <= 1'b0;
        end else begin
            en_q <= tx_en;
            if (rise)
                late <= 1'b0;
            else if (!tx_en && in_stop)
                late <= 1'b1;
            if (rise)
                idle_pend <= 1'b1;
            else if (take_idle)
                idle_pend <= 1'b0;
        end
    end

    assert_rise_queues_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !en_q) |=> idle_pend);

    assert_discard_needs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        discard |-> (tx_en && $past(!tx_en)));

endmodule

// File: rtl/uart_txq_shifter.sv
module uart_txq_shifter
    import uart_txq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  txq_req_t          req,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take_data,
    output logic              take_idle,
    output logic              in_stop,
    output char_kind_e        kind,
    output logic              line_lvl
);

    localparam int CHAR_BITS = char_bits(DATA_W);
    localparam int IDX_W     = $clog2(CHAR_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_BITS - 1);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              char_end;
    char_kind_e        nxt;
    logic [IDX_W-1:0]  sel;
    logic [DATA_W-1:0] shifted;

    assign char_end  = (kind == CH_NONE) || (idx == LAST_IDX);
    assign nxt       = tx_en ? pick_next(req) : CH_NONE;
    assign take_data = baud_tick && char_end && (nxt == CH_DATA);
    assign take_idle = baud_tick && char_end && (nxt == CH_IDLE);
    assign in_stop   = (kind == CH_DATA) && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind <= CH_NONE;
            idx  <= '0;
            sh   <= '0;
        end else if (baud_tick) begin
            if (char_end) begin
                kind <= nxt;
                idx  <= '0;
                if (nxt == CH_DATA)
                    sh <= buf_data;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    always_comb begin
        sel      = idx - IDX_W'(1);
        shifted  = sh >> sel;
        line_lvl = 1'b1;
        case (kind)
            CH_DATA: begin
                if (idx == '0)
                    line_lvl = 1'b0;
                else if (idx == LAST_IDX)
                    line_lvl = 1'b1;
                else
                    line_lvl = shifted[0];
            end
            CH_BREAK: line_lvl = 1'b0;
            default:  line_lvl = 1'b1;
        endcase
    end

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        idx <= LAST_IDX);

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(line_lvl));

    assert_off_stays_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && kind == CH_NONE) |=> kind == CH_NONE);

endmodule

// File: rtl/uart_tx_idleq.sv
module uart_tx_idleq
    import uart_txq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              tx_inv,
    input  logic              brk_req,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_empty_en,
    input  logic              irq_done_en,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq
);

    localparam int N_SRC = 2;

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take_data;
    logic              take_idle;
    logic              in_stop;
    logic              idle_pend;
    logic              discard;
    logic              line_lvl;
    char_kind_e        kind;
    txq_req_t          req;
    logic [N_SRC-1:0]  src;
    logic [N_SRC-1:0]  ena;
    logic [N_SRC-1:0]  hit;

    uart_txq_hold #(.DATA_W(DATA_W)) hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take_data),
        .drop    (discard),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_txq_enq enq_i (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .in_stop   (in_stop),
        .take_idle (take_idle),
        .idle_pend (idle_pend),
        .discard   (discard)
    );

    assign req.idle = idle_pend;
    assign req.brk  = brk_req;
    assign req.data = hold_full;

    uart_txq_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .req       (req),
        .buf_data  (hold_data),
        .take_data (take_data),
        .take_idle (take_idle),
        .in_stop   (in_stop),
        .kind      (kind),
        .line_lvl  (line_lvl)
    );

    assign txd       = line_lvl ^ tx_inv;
    assign buf_empty = !hold_full;
    assign tx_done   = (kind == CH_NONE) && !hold_full && !idle_pend
                       && !(brk_req && tx_en);

    assign src = {tx_done, buf_empty};
    assign ena = {irq_done_en, irq_empty_en};

    for (genvar g = 0; g < N_SRC; g++) begin : g_irq_src
        assign hit[g] = src[g] && ena[g];
    end

    assign irq = |hit;

    assert_done_clear_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !tx_done);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (!irq_empty_en && !irq_done_en) |-> !irq);

    assert_done_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> buf_empty);

endmodule

// File: tb/uart_tx_idleq_tb_top.sv
module uart_tx_idleq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       tx_inv = 1'b0;
    logic       brk_req = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_empty_en = 1'b0;
    logic       irq_done_en = 1'b0;
    logic       txd;
    logic       buf_empty;
    logic       tx_done;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    uart_tx_idleq #(.DATA_W(8)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .baud_tick    (baud_tick),
        .tx_en        (tx_en),
        .tx_inv       (tx_inv),
        .brk_req      (brk_req),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .irq_empty_en (irq_empty_en),
        .irq_done_en  (irq_done_en),
        .txd          (txd),
        .buf_empty    (buf_empty),
        .tx_done      (tx_done),
        .irq          (irq)
    );

    function automatic logic [9:0] frame_pat(input logic [7:0] d);
        return {1'b1, d, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick_sample(output logic b);
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        b = txd;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic expect_bits(input string tag, input logic [9:0] pat,
                               input int first, input logic inv);
        logic b;
        for (int i = first; i < 10; i++) begin
            tick_sample(b);
            chk(tag, b, pat[i] ^ inv);
        end
    endtask

    task automatic settle_idle(input string tag);
        logic b;
        tick_sample(b);
        chk(tag, b, 1'b1 ^ tx_inv);
        chk(tag, tx_done, 1'b1);
    endtask

    task automatic test_reset;
        @(negedge clk);
        chk("R1 txd", txd, 1'b1);
        chk("R1 buf_empty", buf_empty, 1'b1);
        chk("R1 tx_done", tx_done, 1'b1);
        chk("R1 irq", irq, 1'b0);
        @(negedge clk) irq_done_en = 1'b1;
        @(negedge clk) chk("R10 done gate on", irq, 1'b1);
        irq_done_en = 1'b0;
    endtask

    task automatic test_enable_idle;
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk) chk("R5 done low while idle queued", tx_done, 1'b0);
        expect_bits("R6 idle char", 10'h3FF, 0, 1'b0);
        chk("R5 done low during idle char", tx_done, 1'b0);
        settle_idle("R5 done after idle char");
    endtask

    task automatic test_frame(input logic [7:0] d);
        logic b;
        host_write(d);
        chk("R4 empty cleared by write", buf_empty, 1'b0);
        chk("R5 done cleared by write", tx_done, 1'b0);
        tick_sample(b);
        chk("R2 start bit", b, 1'b0);
        chk("R4 empty after load", buf_empty, 1'b1);
        expect_bits("R2 frame bits", frame_pat(d), 1, 1'b0);
        settle_idle("R2 rest after frame");
    endtask

    task automatic test_queue_order;
        logic b;
        host_write(8'h81);
        tick_sample(b);
        chk("R6 start A", b, 1'b0);
        host_write(8'h7E);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk) chk("R6 byte kept before stop", buf_empty, 1'b0);
        expect_bits("R6 frame A", frame_pat(8'h81), 1, 1'b0);
        expect_bits("R6 idle between", 10'h3FF, 0, 1'b0);
        chk("R6 B still waiting", buf_empty, 1'b0);
        expect_bits("R6 frame B", frame_pat(8'h7E), 0, 1'b0);
        settle_idle("R6 rest after B");
    endtask

    task automatic test_late_toggle;
        logic b;
        host_write(8'h55);
        tick_sample(b);
        host_write(8'hC3);
        expect_bits("R7 frame A", frame_pat(8'h55), 1, 1'b0);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk) chk("R7 byte discarded", buf_empty, 1'b1);
        expect_bits("R7 idle only", 10'h3FF, 0, 1'b0);
        settle_idle("R7 B never sent");
        tick_sample(b);
        chk("R7 line stays idle", b, 1'b1);
    endtask

    task automatic test_disable;
        logic b;
        host_write(8'h0F);
        tick_sample(b);
        @(negedge clk) tx_en = 1'b0;
        host_write(8'hF0);
        expect_bits("R9 frame finishes", frame_pat(8'h0F), 1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick_sample(b);
            chk("R9 rest while off", b, 1'b1);
        end
        chk("R9 byte held", buf_empty, 1'b0);
        chk("R9 done low with byte held", tx_done, 1'b0);
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk) chk("R7 held byte discarded", buf_empty, 1'b1);
        expect_bits("R7 idle after re-enable", 10'h3FF, 0, 1'b0);
        settle_idle("R7 rest after re-enable");
    endtask

    task automatic test_break;
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) chk("R5 done low on break request", tx_done, 1'b0);
        host_write(8'h99);
        expect_bits("R8 break before data", 10'h000, 0, 1'b0);
        @(negedge clk) brk_req = 1'b0;
        expect_bits("R8 data after break", frame_pat(8'h99), 0, 1'b0);
        settle_idle("R8 rest after break");
    endtask

    task automatic test_invert;
        logic b;
        @(negedge clk) tx_inv = 1'b1;
        @(negedge clk) chk("R3 rest inverted", txd, 1'b0);
        host_write(8'h5A);
        expect_bits("R3 frame inverted", frame_pat(8'h5A), 0, 1'b1);
        settle_idle("R3 rest inverted after frame");
        @(negedge clk) brk_req = 1'b1;
        expect_bits("R3 break inverted", 10'h000, 0, 1'b1);
        @(negedge clk) brk_req = 1'b0;
        settle_idle("R3 rest inverted after break");
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
        expect_bits("R3 idle char inverted", 10'h3FF, 0, 1'b1);
        settle_idle("R3 rest after idle");
        @(negedge clk) tx_inv = 1'b0;
    endtask

    task automatic test_irq;
        logic b;
        @(negedge clk) begin irq_empty_en = 1'b1; irq_done_en = 1'b0; end
        @(negedge clk) chk("R10 empty source", irq, 1'b1);
        host_write(8'h11);
        chk("R10 nothing pending", irq, 1'b0);
        @(negedge clk) irq_done_en = 1'b1;
        @(negedge clk) chk("R10 done still low", irq, 1'b0);
        tick_sample(b);
        chk("R10 empty after load", irq, 1'b1);
        @(negedge clk) irq_empty_en = 1'b0;
        @(negedge clk) chk("R10 empty gated off", irq, 1'b0);
        expect_bits("R10 frame", frame_pat(8'h11), 1, 1'b0);
        tick_sample(b);
        chk("R10 done source", irq, 1'b1);
        @(negedge clk) irq_done_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_enable_idle();
        test_frame(8'hA5);
        test_frame(8'h3C);
        test_queue_order();
        test_late_toggle();
        test_disable();
        test_break();
        test_invert();
        test_irq();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule